// File: doc/BRIEF.md
# UART In-Band Flow Control Engine

This block gives one UART channel in-band resume/stop flow control. It sits on two paths. On the receive path, each byte from the deserialiser is compared with programmed resume and stop characters before it reaches the receive FIFO. A recognised byte is consumed and never delivered. A stop halts the local transmitter and a resume releases it. On the transmit path, the block chooses each character handed to the shifter. That character is a pending flow-control character, the second half of a two-character sequence, or the next FIFO data byte when the transmitter is not halted.

A 4-bit control field sets the behaviour. Bits [3:2] choose which characters are transmitted. Bits [1:0] choose how received bytes are compared. The two halves are set independently. Four character inputs hold the two resume codes and the two stop codes. Pulses on `send_stop` and `send_resume` ask the block to emit a stop or resume at the next free transmit slot.

Top module: `xonxoff_fc`

## Requirements
- R1: After reset `rx_out_valid` is 0 and no request is pending. The halt flag is clear, so with `tx_fifo_valid` and `tx_ready` high, `tx_load` and `tx_fifo_pop` are 1 and `tx_byte` equals `tx_fifo_byte`.
- R2: Receive compare field ctrl[1:0]. With 00 every byte is forwarded. With 10 only `xon1`/`xoff1` are recognised, and with 01 only `xon2`/`xoff2`. Recognised bytes are dropped. All other bytes are forwarded unchanged and in arrival order.
- R3: With ctrl[1:0]=11 and ctrl[3:2] not 11, either resume code means resume and either stop code means stop.
- R4: With ctrl=1111, resume needs `xon1` directly followed by `xon2`, and stop needs `xoff1` directly followed by `xoff2`. In that case both bytes are dropped. If the second byte does not complete the pair, the held first byte is forwarded, and the second byte is then judged as if no pair had started.
- R5: A recognised stop sets the halt flag and a recognised resume clears it. While the flag is set, no FIFO data byte is loaded. If a byte matches both a stop and a resume code, stop wins.
- R6: A request pulse is taken up at the next slot where `tx_ready` is high, ahead of FIFO data, even while halted. ctrl[3:2]=10 sends `xoff1`/`xon1`, 01 sends `xoff2`/`xon2`, and 11 sends the first code of the pair. With 00, requests are ignored. If both pulses arrive in one cycle, stop wins.
- R7: With ctrl[3:2]=11 the code pair (`xoff1` then `xoff2`, or `xon1` then `xon2`) fills two consecutive loads. No data byte comes between them, even when `tx_ready` has gaps.
- R8: A change of the control field while the first byte of a receive pair is held drops the partial match. The held byte appears on `rx_out_byte` one cycle after the change.
- R9: A forwarded byte appears on `rx_out_valid`/`rx_out_byte` one cycle after its `rx_valid`. A byte forwarded after a broken pair appears one cycle after the held byte. Input bytes must be at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl | input | 4 | [3:2] transmit select, [1:0] receive compare select |
| xon1 | input | 8 | First resume code |
| xon2 | input | 8 | Second resume code |
| xoff1 | input | 8 | First stop code |
| xoff2 | input | 8 | Second stop code |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_out_valid | output | 1 | Byte for receive FIFO |
| rx_out_byte | output | 8 | Forwarded receive data |
| tx_fifo_valid | input | 1 | Transmit FIFO has data |
| tx_fifo_byte | input | 8 | Head of transmit FIFO |
| tx_fifo_pop | output | 1 | Consume FIFO head |
| tx_ready | input | 1 | Shifter accepts a character this cycle |
| tx_load | output | 1 | Character handed to shifter |
| tx_byte | output | 8 | Character handed to shifter |
| send_stop | input | 1 | Request to send stop |
| send_resume | input | 1 | Request to send resume |

## Verification
Two functions can fall due at the same transmit slot: a pending flow-control insertion and a waiting FIFO data byte. Likewise, a received stop can coincide with the halted transmitter being asked to send resume. The bench provokes both. It keeps `tx_fifo_valid` high while pulsing requests, and it requests resume after a stop has been received. It then checks each load's byte and order against the code sequence expected for every transmit mode. On the receive side, every ordered pair of the four codes and plain data is swept under all sixteen control values. The forwarded stream and halt state are compared with an arithmetic model.

// File: rtl/xonxoff_fc.sv
module xonxoff_fc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   ctrl,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  output logic         rx_out_valid,
  output logic [W-1:0] rx_out_byte,
  input  logic         tx_fifo_valid,
  input  logic [W-1:0] tx_fifo_byte,
  output logic         tx_fifo_pop,
  input  logic         tx_ready,
  output logic         tx_load,
  output logic [W-1:0] tx_byte,
  input  logic         send_stop,
  input  logic         send_resume
);
  localparam logic [1:0] S_IDLE = 2'd0, S_ON = 2'd1, S_OFF = 2'd2;

  logic [1:0]   st;
  logic [W-1:0] held, pend_b;
  logic         pend_v, halt;
  logic         req_pend, req_stop, sec_pend, sec_stop;
  logic [3:0]   ctrl_q;
  logic         m_on, m_off;

  wire [1:0] tm  = ctrl[3:2];
  wire [1:0] rm  = ctrl[1:0];
  wire       seq = &ctrl;

  always_comb begin
    m_on  = 1'b0;
    m_off = 1'b0;
    case (rm)
      2'b10: begin m_on = rx_byte == xon1; m_off = rx_byte == xoff1; end
      2'b01: begin m_on = rx_byte == xon2; m_off = rx_byte == xoff2; end
      2'b11: begin
        m_on  = (rx_byte == xon1)  || (rx_byte == xon2);
        m_off = (rx_byte == xoff1) || (rx_byte == xoff2);
      end
      default: ;
    endcase
  end

  wire i_start_off = seq && (rx_byte == xoff1);
  wire i_start_on  = seq && !i_start_off && (rx_byte == xon1);
  wire i_stop      = !seq && m_off;
  wire i_go        = !seq && !m_off && m_on;

  wire waiting = st != S_IDLE;
  wire abandon = waiting && (ctrl != ctrl_q);
  wire done    = waiting && !abandon && rx_valid &&
                 ((st == S_ON) ? (rx_byte == xon2) : (rx_byte == xoff2));
  wire flush   = waiting && (abandon || (rx_valid && !done));
  wire eval_b  = rx_valid && (!waiting || flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      held         <= '0;
      pend_v       <= 1'b0;
      pend_b       <= '0;
      halt         <= 1'b0;
      ctrl_q       <= '0;
      rx_out_valid <= 1'b0;
      rx_out_byte  <= '0;
    end else begin
      ctrl_q       <= ctrl;
      rx_out_valid <= pend_v;
      pend_v       <= 1'b0;
      if (pend_v) rx_out_byte <= pend_b;
      if (flush) begin
        rx_out_valid <= 1'b1;
        rx_out_byte  <= held;
        st           <= S_IDLE;
      end
      if (done) begin
        st   <= S_IDLE;
        halt <= (st == S_OFF);
      end
      if (eval_b) begin
        if (i_start_off) begin
          st   <= S_OFF;
          held <= rx_byte;
        end else if (i_start_on) begin
          st   <= S_ON;
          held <= rx_byte;
        end else if (i_stop) begin
          halt <= 1'b1;
        end else if (i_go) begin
          halt <= 1'b0;
        end else if (flush) begin
          pend_v <= 1'b1;
          pend_b <= rx_byte;
        end else begin
          rx_out_valid <= 1'b1;
          rx_out_byte  <= rx_byte;
        end
      end
    end
  end

  wire ins_ok  = req_pend && (tm != 2'b00);
  wire sel_sec = sec_pend;
  wire sel_ins = !sec_pend && ins_ok;
  wire sel_dat = !sec_pend && !ins_ok && !halt && tx_fifo_valid;

  wire [W-1:0] c_first = req_stop ? ((tm == 2'b01) ? xoff2 : xoff1)
                                  : ((tm == 2'b01) ? xon2  : xon1);

  assign tx_load     = tx_ready && (sel_sec || sel_ins || sel_dat);
  assign tx_fifo_pop = tx_ready && sel_dat;
  assign tx_byte     = sel_sec ? (sec_stop ? xoff2 : xon2)
                     : sel_ins ? c_first : tx_fifo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pend <= 1'b0;
      req_stop <= 1'b0;
      sec_pend <= 1'b0;
      sec_stop <= 1'b0;
    end else begin
      if (tm == 2'b00) req_pend <= 1'b0;
      else if (tx_ready && sel_ins) req_pend <= 1'b0;
      if (tx_ready && sel_sec) sec_pend <= 1'b0;
      if (tx_ready && sel_ins && tm == 2'b11) begin
        sec_pend <= 1'b1;
        sec_stop <= req_stop;
      end
      if ((send_stop || send_resume) && tm != 2'b00) begin
        req_pend <= 1'b1;
        req_stop <= send_stop;
      end
    end
  end
endmodule

module xonxoff_fc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctrl,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] xon1,
  input logic [7:0] xoff1,
  input logic       rx_out_valid,
  input logic [7:0] rx_out_byte,
  input logic       tx_fifo_pop,
  input logic       tx_load,
  input logic       halt,
  input logic       sec_pend,
  input logic [1:0] st
);
  a_r6_pop_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_pop |-> tx_load);
  a_r5_halt_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !tx_fifo_pop);
  a_r7_pair_not_split: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pend |-> !tx_fifo_pop);
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ctrl[1:0] == 2'b00 && st == 2'd0)
      |=> (rx_out_valid && rx_out_byte == $past(rx_byte)));
  a_r4_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ctrl == 4'hF && st == 2'd0 && (rx_byte == xon1 || rx_byte == xoff1))
      |=> !rx_out_valid);
endmodule

bind xonxoff_fc xonxoff_fc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .xon1(xon1), .xoff1(xoff1), .rx_out_valid(rx_out_valid), .rx_out_byte(rx_out_byte),
  .tx_fifo_pop(tx_fifo_pop), .tx_load(tx_load), .halt(halt), .sec_pend(sec_pend),
  .st(st)
);

// File: tb/xonxoff_fc_tb.sv
`timescale 1ns/1ps
module xonxoff_fc_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] ctrl = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h12, xoff1 = 8'h13, xoff2 = 8'h14;
  logic rx_valid = 0; logic [7:0] rx_byte = 0;
  logic rx_out_valid; logic [7:0] rx_out_byte;
  logic tx_fifo_valid = 0; logic [7:0] tx_fifo_byte = 8'h55;
  logic tx_fifo_pop, tx_ready = 0, tx_load; logic [7:0] tx_byte;
  logic send_stop = 0, send_resume = 0;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] got[$], exq[$];
  int mst = 0; logic [7:0] mheld; bit mhalt = 0;

  always #2 clk = ~clk;

  xonxoff_fc dut_i (.*);

  always @(negedge clk) if (rx_out_valid) got.push_back(rx_out_byte);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sym(input int i);
    case (i)
      0: return xon1; 1: return xon2; 2: return xoff1; 3: return xoff2;
      default: return 8'h41;
    endcase
  endfunction

  task automatic model_byte(input logic [7:0] b);
    bit on, off;
    if (mst != 0) begin
      if (mst == 1 && b == xon2) begin mhalt = 0; mst = 0; return; end
      if (mst == 2 && b == xoff2) begin mhalt = 1; mst = 0; return; end
      exq.push_back(mheld); mst = 0;
    end
    if (ctrl == 4'hF) begin
      if (b == xoff1) begin mst = 2; mheld = b; end
      else if (b == xon1) begin mst = 1; mheld = b; end
      else exq.push_back(b);
    end else begin
      on  = (ctrl[1] && b == xon1)  || (ctrl[0] && b == xon2);
      off = (ctrl[1] && b == xoff1) || (ctrl[0] && b == xoff2);
      if (off) mhalt = 1; else if (on) mhalt = 0; else exq.push_back(b);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b; model_byte(b);
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic halt_check(input string tag, input bit exp_halt);
    @(negedge clk); tx_fifo_valid = 1; tx_ready = 1;
    #1 check(tx_load == !exp_halt, tag, tx_load, !exp_halt);
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic tx_slot(output bit ld, output logic [7:0] by);
    @(negedge clk); tx_ready = 1;
    #1 ld = tx_load; by = tx_byte;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ld; logic [7:0] by;
    logic [7:0] e[3];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rx_out_valid, "R1 rx idle", rx_out_valid, 0);
    tx_fifo_valid = 1; tx_ready = 1;
    #1 check(tx_load && tx_fifo_pop && tx_byte == 8'h55, "R1 data passes", tx_byte, 8'h55);
    @(negedge clk); tx_ready = 0;

    @(negedge clk); ctrl = 4'h0; rx_valid = 1; rx_byte = 8'h77;
    @(negedge clk); rx_valid = 0;
    check(rx_out_valid && rx_out_byte == 8'h77, "R9 one-cycle latency", rx_out_byte, 8'h77);
    @(negedge clk);
    check(!rx_out_valid, "R9 single strobe", rx_out_valid, 0);

    for (int c = 0; c < 16; c++) begin
      @(negedge clk); ctrl = c[3:0];
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++) begin
          string tag;
          tag = (c[1:0] != 2'b11) ? "R2" : (c == 15) ? "R4" : "R3";
          got.delete(); exq.delete();
          send_rx(sym(a)); send_rx(sym(b)); send_rx(8'h41);
          repeat (2) @(negedge clk);
          begin
            bit same;
            same = got.size() == exq.size();
            if (same) foreach (exq[i]) if (got[i] !== exq[i]) same = 0;
            check(same, $sformatf("%s stream ctrl=%0h pair=%0d%0d", tag, c, a, b),
                  got.size(), exq.size());
          end
          halt_check($sformatf("R5 halt ctrl=%0h pair=%0d%0d", c, a, b), mhalt);
        end
    end

    @(negedge clk); ctrl = 4'hF; rx_valid = 1; rx_byte = xon1;
    @(negedge clk); rx_valid = 0;
    check(!rx_out_valid, "R4 first held", rx_out_valid, 0);
    @(negedge clk); rx_valid = 1; rx_byte = 8'h41;
    @(negedge clk); rx_valid = 0;
    check(rx_out_valid && rx_out_byte == xon1, "R9 held byte first", rx_out_byte, xon1);
    @(negedge clk);
    check(rx_out_valid && rx_out_byte == 8'h41, "R9 next byte after", rx_out_byte, 8'h41);

    @(negedge clk); rx_valid = 1; rx_byte = xoff1;
    @(negedge clk); rx_valid = 0;
    @(negedge clk); ctrl = 4'h0;
    @(negedge clk);
    check(rx_out_valid && rx_out_byte == xoff1, "R8 held byte flushed", rx_out_byte, xoff1);

    xon1 = 8'h13; ctrl = 4'h2;
    got.delete(); exq.delete(); mhalt = 0;
    send_rx(8'h13);
    halt_check("R5 stop wins", 1);
    xon1 = 8'h11;
    send_rx(xon1);
    halt_check("R5 resume", 0);

    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 2; k++) begin
        @(negedge clk); ctrl = {t[1:0], 2'b00}; tx_fifo_valid = 1;
        send_stop = (k == 1); send_resume = (k == 0);
        @(negedge clk); send_stop = 0; send_resume = 0;
        e[0] = 8'h55; e[1] = 8'h55; e[2] = 8'h55;
        if (t == 2) e[0] = k ? xoff1 : xon1;
        if (t == 1) e[0] = k ? xoff2 : xon2;
        if (t == 3) begin e[0] = k ? xoff1 : xon1; e[1] = k ? xoff2 : xon2; end
        for (int s = 0; s < 3; s++) begin
          tx_slot(ld, by);
          check(ld && by == e[s],
                $sformatf("%s tm=%0d kind=%0d slot=%0d", (t == 3) ? "R7" : "R6", t, k, s),
                by, e[s]);
        end
      end

    @(negedge clk); ctrl = 4'hA;
    send_rx(xoff1);
    @(negedge clk); send_resume = 1;
    @(negedge clk); send_resume = 0;
    tx_slot(ld, by);
    check(ld && by == xon1, "R6 insert while halted", by, xon1);
    tx_slot(ld, by);
    check(!ld, "R5 still halted", ld, 0);
    @(negedge clk); send_stop = 1; send_resume = 1;
    @(negedge clk); send_stop = 0; send_resume = 0;
    tx_slot(ld, by);
    check(ld && by == xoff1, "R6 stop wins request", by, xoff1);
    send_rx(xon1);
    tx_slot(ld, by);
    check(ld && by == 8'h55, "R5 released", by, 8'h55);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule